// File: doc/BRIEF.md
# Register-Mapped Serial Port with Queues

This block is an asynchronous serial transceiver behind a simple 32-bit register bus. Software configures it through a control word, a baud divisor and a queue-threshold word. It sends bytes by writing them to a data register, and collects received bytes by reading that same register. Each byte read comes back with three per-character error flags. A status word reports whether the transmit queue has drained, whether received data is waiting, and whether a received byte was lost because the receive queue was full.

Inside the block there are five parts. A divisor-driven tick generator produces a 16x oversample strobe. A transmit serializer and a receive deserializer each use optional even or odd parity and one stop bit. Two small first-in first-out queues sit between the bus and the serializers. Line control covers forcing a break on the transmit pin and an internal loopback that routes the transmit serializer into the receiver. The bus uses a single access per cycle: a write takes effect at the clock edge, and read data is valid combinationally in the cycle of the read. A read of the data register pops the oldest entry at that edge.

Top module: `sio_port`

## Requirements
- R1: Registers sit at byte offsets 0x00 (control), 0x04 (divisor), 0x08 (queue thresholds), 0x10 (status) and 0x14 (data). Control keeps bits 4:0, 6 through 14 and 16 through 23, and reads 0 in bits 5, 15 and 31:24. The divisor keeps its low 16 bits. The thresholds word keeps bits 15:8 and reads 0 elsewhere.
- R2: Control bit 6 empties the receive queue and control bit 7 empties the transmit queue. Each of these bits reads back as 0 from the second cycle after the write that set it.
- R3: While control bit 23 is 1, an oversample tick occurs once every 2*(divisor+1) clocks. One line bit lasts 16 ticks.
- R4: While control bit 22 is 1, bytes written to the data register leave on `txd` in write order. Each frame is a low start bit, then 8 data bits with the least significant bit first, then an optional parity bit, then one high stop bit. Up to 4 bytes may be written back to back.
- R5: Control bit 19 adds a transmit parity bit. Control bit 18 set to 1 selects even parity, where the count of ones over the data and parity bits is even; set to 0 it selects odd parity.
- R6: Control bit 14 holds `txd` low while it is set.
- R7: Control bit 20 feeds the transmit serializer into the receiver and holds `txd` high.
- R8: While control bit 21 is 1, the receiver samples each bit on the 8th oversample tick of that bit. A data-register read returns the oldest byte in bits 7:0 and removes it from the queue. A read with the receive queue empty returns 0.
- R9: Received entries carry three flags. Bit 8 is set when the stop bit was low. Bit 9 is set when receive parity is enabled by control bit 17 and the parity bit is wrong, with control bit 16 choosing even parity. Bit 10 is set when the data, parity and stop bits were all low.
- R10: Status bit 5 is 1 when the transmit queue is empty and bit 11 is 1 when the receive queue holds data. Bit 7 latches when a byte arrives with the receive queue full, and that byte is dropped. Bit 7 clears on a status-register write with bit 7 zero, or on a receive-queue reset.
- R11: While control bit 21 is 0, frames on `rxd` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (pops the receive queue at offset 0x14) |
| addr | input | 5 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the read cycle |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |

## Verification
The assertions take four things for granted. There is at most one bus access per cycle. The `rxd` line is already synchronous to `clk`, since there is no synchronizer in front of the receiver. The divisor and the parity settings do not change while a frame is in flight. The hold properties for the overrun flag and the self-clearing reset bits also assume that a control or status write is the only way software touches them. The stimulus drives every bus access and every `rxd` bit on the falling clock edge. It reprograms control and divisor only after the transmit queue has drained and the last frame has finished. It also waits a full idle bit time after each received stop bit, so that the receiver is always re-armed before the next frame.

// File: rtl/sio_pkg.sv
package sio_pkg;
    localparam logic [4:0] OFS_CTL  = 5'h00;
    localparam logic [4:0] OFS_DIV  = 5'h04;
    localparam logic [4:0] OFS_THR  = 5'h08;
    localparam logic [4:0] OFS_STAT = 5'h10;
    localparam logic [4:0] OFS_DATA = 5'h14;

    localparam int C_RXCLR  = 6;
    localparam int C_TXCLR  = 7;
    localparam int C_BREAK  = 14;
    localparam int C_RXEVEN = 16;
    localparam int C_RXPAR  = 17;
    localparam int C_TXEVEN = 18;
    localparam int C_TXPAR  = 19;
    localparam int C_LOOP   = 20;
    localparam int C_RXON   = 21;
    localparam int C_TXON   = 22;
    localparam int C_TICKON = 23;

    localparam int S_TXIDLE = 5;
    localparam int S_LOST   = 7;
    localparam int S_RXHAVE = 11;

    localparam logic [23:0] CTL_KEEP = 24'hFF7FDF;

    typedef enum logic [2:0] {PH_IDLE, PH_START, PH_DATA, PH_PAR, PH_STOP} phase_t;
endpackage

// File: rtl/sio_fifo.sv
module sio_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [AW:0]   cnt;
    } fifo_s;

    fifo_s q, d;
    logic [W-1:0] mem [DEPTH];
    logic do_push, do_pop;

    assign empty   = (q.cnt == '0);
    assign full    = (q.cnt == (AW+1)'(DEPTH));
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign dout    = mem[q.rp];

    always_comb begin
        d = q;
        if (flush) begin
            d = '0;
        end else begin
            if (do_push) d.wp = q.wp + 1'b1;
            if (do_pop)  d.rp = q.rp + 1'b1;
            d.cnt = q.cnt + (AW+1)'(do_push) - (AW+1)'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[q.wp] <= din;
    end

    p_flush_empties_r2: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);
    p_full_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> full);
endmodule

// File: rtl/sio_tick.sv
module sio_tick #(
    parameter int BW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [BW-1:0] word,
    output logic          tick
);
    logic [BW:0] cnt_d, cnt_q;
    logic        wrap;

    assign wrap = (cnt_q >= {word, 1'b1});
    assign tick = en && wrap;

    always_comb begin
        if (!en)       cnt_d = '0;
        else if (wrap) cnt_d = '0;
        else           cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/sio_tx.sv
module sio_tx
    import sio_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       en,
    input  logic       par_en,
    input  logic       par_even,
    input  logic       have,
    input  logic [7:0] data,
    output logic       pop,
    output logic       line
);
    typedef struct packed {
        phase_t     ph;
        logic [7:0] sh;
        logic [2:0] bitn;
        logic [3:0] tcnt;
        logic       par;
    } tx_s;

    tx_s q, d;

    always_comb begin
        d   = q;
        pop = 1'b0;
        if (q.ph == PH_IDLE) begin
            if (en && have) begin
                pop    = 1'b1;
                d.sh   = data;
                d.par  = par_even ? ^data : ~^data;
                d.ph   = PH_START;
                d.tcnt = '0;
            end
        end else if (tick) begin
            d.tcnt = q.tcnt + 4'd1;
            if (q.tcnt == 4'd15) begin
                case (q.ph)
                    PH_START: begin
                        d.ph   = PH_DATA;
                        d.bitn = '0;
                    end
                    PH_DATA: begin
                        d.sh   = {1'b0, q.sh[7:1]};
                        d.bitn = q.bitn + 3'd1;
                        if (q.bitn == 3'd7) d.ph = par_en ? PH_PAR : PH_STOP;
                    end
                    PH_PAR:  d.ph = PH_STOP;
                    default: d.ph = PH_IDLE;
                endcase
            end
        end
    end

    always_comb begin
        case (q.ph)
            PH_START: line = 1'b0;
            PH_DATA:  line = q.sh[0];
            PH_PAR:   line = q.par;
            default:  line = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{ph: PH_IDLE, default: '0};
        else        q <= d;
    end

    p_pop_has_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> have);
endmodule

// File: rtl/sio_rx.sv
module sio_rx
    import sio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        en,
    input  logic        line,
    input  logic        par_en,
    input  logic        par_even,
    output logic        push,
    output logic [10:0] word
);
    typedef struct packed {
        phase_t     ph;
        logic [7:0] sh;
        logic [2:0] bitn;
        logic [3:0] tcnt;
        logic       armed;
        logic       pbit;
    } rx_s;

    rx_s  q, d;
    logic want_par, ferr, perr, brk;

    assign want_par = par_even ? ^q.sh : ~^q.sh;
    assign ferr     = !line;
    assign perr     = par_en && (q.pbit != want_par);
    assign brk      = !line && (q.sh == 8'h00) && !(par_en && q.pbit);
    assign word     = {brk, perr, ferr, q.sh};

    always_comb begin
        d    = q;
        push = 1'b0;
        if (!en) begin
            d.ph    = PH_IDLE;
            d.armed = 1'b0;
        end else if (tick) begin
            d.tcnt = q.tcnt + 4'd1;
            case (q.ph)
                PH_IDLE: begin
                    if (line) begin
                        d.armed = 1'b1;
                    end else if (q.armed) begin
                        d.ph    = PH_START;
                        d.tcnt  = '0;
                        d.armed = 1'b0;
                    end
                end
                PH_START: begin
                    if (q.tcnt == 4'd6) begin
                        d.tcnt = '0;
                        d.bitn = '0;
                        d.ph   = line ? PH_IDLE : PH_DATA;
                    end
                end
                PH_DATA: begin
                    if (q.tcnt == 4'd15) begin
                        d.sh   = {line, q.sh[7:1]};
                        d.bitn = q.bitn + 3'd1;
                        if (q.bitn == 3'd7) d.ph = par_en ? PH_PAR : PH_STOP;
                    end
                end
                PH_PAR: begin
                    if (q.tcnt == 4'd15) begin
                        d.pbit = line;
                        d.ph   = PH_STOP;
                    end
                end
                default: begin
                    if (q.tcnt == 4'd15) begin
                        push    = 1'b1;
                        d.ph    = PH_IDLE;
                        d.armed = 1'b0;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{ph: PH_IDLE, default: '0};
        else        q <= d;
    end

    p_off_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (q.ph == PH_IDLE));
endmodule

// File: rtl/sio_port.sv
module sio_port
    import sio_pkg::*;
#(
    parameter int BW    = 16,
    parameter int DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [4:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    input  logic        rxd,
    output logic        txd
);
    localparam int RXW = 11;

    typedef struct packed {
        logic [23:0]   ctl;
        logic [BW-1:0] div;
        logic [7:0]    thr;
        logic          lost;
    } regs_s;

    regs_s q, d;

    logic           tick, tx_line, rx_line;
    logic           tx_empty, tx_full, tx_pop;
    logic [7:0]     tx_data;
    logic           rx_empty, rx_full, rx_push;
    logic [RXW-1:0] rx_word, rx_head;
    logic           tx_flush, rx_flush, wr_data, rd_data, wr_ctl, stat_clr;
    logic [31:0]    stat;
    logic           unused_hi;

    assign unused_hi = ^wdata[31:24];
    assign tx_flush  = q.ctl[C_TXCLR];
    assign rx_flush  = q.ctl[C_RXCLR];
    assign wr_ctl    = wr_en && (addr == OFS_CTL);
    assign wr_data   = wr_en && (addr == OFS_DATA);
    assign rd_data   = rd_en && (addr == OFS_DATA);
    assign stat_clr  = wr_en && (addr == OFS_STAT) && !wdata[S_LOST];

    always_comb begin
        d = q;
        d.ctl[C_TXCLR] = 1'b0;
        d.ctl[C_RXCLR] = 1'b0;
        if (wr_en) begin
            case (addr)
                OFS_CTL: d.ctl = wdata[23:0] & CTL_KEEP;
                OFS_DIV: d.div = wdata[BW-1:0];
                OFS_THR: d.thr = wdata[15:8];
                default: ;
            endcase
        end
        if (stat_clr)                        d.lost = 1'b0;
        if (rx_push && rx_full && !rx_flush) d.lost = 1'b1;
        if (rx_flush)                        d.lost = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        stat           = '0;
        stat[S_TXIDLE] = tx_empty;
        stat[S_LOST]   = q.lost;
        stat[S_RXHAVE] = !rx_empty;
        case (addr)
            OFS_CTL:  rdata = {8'h00, q.ctl};
            OFS_DIV:  rdata = 32'(q.div);
            OFS_THR:  rdata = {16'h0000, q.thr, 8'h00};
            OFS_STAT: rdata = stat;
            OFS_DATA: rdata = rx_empty ? 32'h0 : 32'(rx_head);
            default:  rdata = 32'h0;
        endcase
    end

    assign rx_line = q.ctl[C_LOOP] ? tx_line : rxd;
    assign txd     = q.ctl[C_BREAK] ? 1'b0 : (q.ctl[C_LOOP] ? 1'b1 : tx_line);

    sio_tick #(.BW(BW)) u_tick (
        .clk(clk), .rst_n(rst_n), .en(q.ctl[C_TICKON]), .word(q.div), .tick(tick)
    );

    sio_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(tx_flush), .push(wr_data), .din(wdata[7:0]),
        .pop(tx_pop), .dout(tx_data), .empty(tx_empty), .full(tx_full)
    );

    sio_tx u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .en(q.ctl[C_TXON]),
        .par_en(q.ctl[C_TXPAR]), .par_even(q.ctl[C_TXEVEN]), .have(!tx_empty),
        .data(tx_data), .pop(tx_pop), .line(tx_line)
    );

    sio_rx u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .en(q.ctl[C_RXON]), .line(rx_line),
        .par_en(q.ctl[C_RXPAR]), .par_even(q.ctl[C_RXEVEN]), .push(rx_push), .word(rx_word)
    );

    sio_fifo #(.W(RXW), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(rx_flush), .push(rx_push), .din(rx_word),
        .pop(rd_data), .dout(rx_head), .empty(rx_empty), .full(rx_full)
    );

    p_clr_bit_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ctl[C_RXCLR] && !wr_ctl) |=> !q.ctl[C_RXCLR]);
    p_lost_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_full && !rx_flush) |=> q.lost);
    p_lost_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.lost && !rx_flush && !stat_clr) |=> q.lost);
    p_no_tx_push_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && tx_full && !tx_pop) |=> tx_full);
endmodule

// File: tb/sio_port_bench.sv
module sio_port_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rxd = 1'b1;
    logic        txd;

    int n_chk = 0, n_bad = 0;
    int bit_clks = 32;
    bit mon_en = 1'b0, tx_pon = 1'b0, tx_peven = 1'b0, finished = 1'b0;
    logic [31:0] cur_ctl = '0;
    logic [7:0]  exp_q [$];

    localparam logic [31:0] ON_TX = 32'h00C0_0000;
    localparam logic [31:0] ON_RX = 32'h00A0_0000;

    sio_port u_sio_port (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rxd(rxd), .txd(txd));

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [4:0] a, input logic [31:0] v);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = v;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [4:0] a, output logic [31:0] v);
        @(negedge clk); rd_en = 1'b1; addr = a; #1; v = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [4:0] a, input logic [31:0] exp);
        logic [31:0] v;
        bus_rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic set_ctl(input logic [31:0] v);
        cur_ctl = v;
        bus_wr(5'h00, v);
    endtask

    task automatic send_tx(input logic [7:0] b);
        exp_q.push_back(b);
        bus_wr(5'h14, {24'h0, b});
    endtask

    task automatic wait_tx(input string req);
        logic [31:0] s;
        s = '0;
        while (s[5] == 1'b0) bus_rd(5'h10, s);
        repeat (12 * bit_clks) @(negedge clk);
        chk(req, exp_q.size(), 0);
    endtask

    task automatic send_rx(input logic [7:0] b, input bit pon, input bit pbit, input bit stp);
        rxd = 1'b0; repeat (bit_clks) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i]; repeat (bit_clks) @(negedge clk);
        end
        if (pon) begin rxd = pbit; repeat (bit_clks) @(negedge clk); end
        rxd = stp; repeat (bit_clks) @(negedge clk);
        rxd = 1'b1; repeat (bit_clks) @(negedge clk);
    endtask

    // monitor: decode txd and compare against the scoreboard queue
    initial begin
        forever begin
            @(negedge txd);
            if (mon_en) begin
                logic [7:0] got;
                logic [7:0] exp;
                logic       pb;
                repeat (bit_clks / 2) @(negedge clk);
                chk("R4 start", txd, 0);
                for (int i = 0; i < 8; i++) begin
                    repeat (bit_clks) @(negedge clk);
                    got[i] = txd;
                end
                if (exp_q.size() == 0) begin
                    chk("R4 unexpected frame", got, 8'hxx);
                    exp = 8'h00;
                end else begin
                    exp = exp_q.pop_front();
                    chk("R4 data", got, exp);
                end
                if (tx_pon) begin
                    repeat (bit_clks) @(negedge clk);
                    pb = txd;
                    chk("R5 parity", pb, tx_peven ? ^exp : ~^exp);
                end
                repeat (bit_clks) @(negedge clk);
                chk("R4 stop", txd, 1);
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        rd_chk("R1 ctl reset", 5'h00, 32'h0);
        rd_chk("R10 stat reset", 5'h10, 32'h20);
        rd_chk("R8 empty read", 5'h14, 32'h0);

        // register layout and self-clearing queue resets
        set_ctl(32'hFFFF_FFFF);
        rd_chk("R1 R2 ctl readback", 5'h00, 32'h00FF_7F1F);
        set_ctl(32'h0);
        bus_wr(5'h04, 32'h1234_5678);
        rd_chk("R1 divisor", 5'h04, 32'h0000_5678);
        bus_wr(5'h08, 32'hFFFF_FFFF);
        rd_chk("R1 thresholds", 5'h08, 32'h0000_FF00);
        bus_wr(5'h04, 32'h0);

        // transmit queue reset
        bus_wr(5'h14, 32'h11);
        bus_wr(5'h14, 32'h22);
        rd_chk("R10 tx not empty", 5'h10, 32'h0);
        set_ctl(32'h80);
        rd_chk("R2 tx queue emptied", 5'h10, 32'h20);

        // plain transmit, back to back up to queue depth
        mon_en = 1'b1;
        set_ctl(ON_TX);
        send_tx(8'h55); send_tx(8'hA3); send_tx(8'h00); send_tx(8'hFF);
        wait_tx("R4 queue drained");

        // even then odd parity
        tx_pon = 1'b1; tx_peven = 1'b1;
        set_ctl(ON_TX | 32'h000C_0000);
        send_tx(8'h01); send_tx(8'h7E);
        wait_tx("R5 even drained");
        tx_peven = 1'b0;
        set_ctl(ON_TX | 32'h0008_0000);
        send_tx(8'h01); send_tx(8'h80);
        wait_tx("R5 odd drained");
        tx_pon = 1'b0;

        // slower divisor: two clocks more per tick
        set_ctl(ON_TX);
        bit_clks = 64;
        bus_wr(5'h04, 32'h1);
        send_tx(8'h3C);
        wait_tx("R3 divisor one");
        bus_wr(5'h04, 32'h0);
        bit_clks = 32;

        // break
        mon_en = 1'b0;
        set_ctl(ON_TX | 32'h4000);
        repeat (3) @(negedge clk);
        chk("R6 break low", txd, 0);
        set_ctl(ON_TX);
        repeat (3) @(negedge clk);
        chk("R6 break released", txd, 1);

        // loopback with parity both ways
        set_ctl(ON_TX | ON_RX | 32'h001F_0000);
        bus_wr(5'h14, 32'hC5);
        repeat (3 * bit_clks) @(negedge clk);
        chk("R7 txd held high", txd, 1);
        repeat (12 * bit_clks) @(negedge clk);
        rd_chk("R7 R10 loop status", 5'h10, 32'h820);
        rd_chk("R7 R8 loop byte", 5'h14, 32'h0C5);
        rd_chk("R8 popped", 5'h10, 32'h20);

        // external receive and error flags
        set_ctl(ON_RX);
        send_rx(8'h96, 0, 0, 1);
        rd_chk("R8 rx byte", 5'h14, 32'h096);
        send_rx(8'h5A, 0, 0, 0);
        rd_chk("R9 framing", 5'h14, 32'h15A);
        send_rx(8'h00, 0, 0, 0);
        rd_chk("R9 break", 5'h14, 32'h500);
        set_ctl(ON_RX | 32'h0003_0000);
        send_rx(8'h03, 1, 1, 1);
        rd_chk("R9 parity wrong", 5'h14, 32'h203);
        set_ctl(ON_RX | 32'h0002_0000);
        send_rx(8'h03, 1, 1, 1);
        rd_chk("R9 parity right", 5'h14, 32'h003);

        // overrun, cleared by status write
        set_ctl(ON_RX);
        for (int i = 0; i < 5; i++) send_rx(8'h10 + 8'(i), 0, 0, 1);
        rd_chk("R10 overrun", 5'h10, 32'h8A0);
        rd_chk("R10 oldest kept", 5'h14, 32'h010);
        bus_wr(5'h10, 32'h0);
        rd_chk("R10 status clear", 5'h10, 32'h820);
        // overrun again, cleared by receive queue reset
        for (int i = 0; i < 2; i++) send_rx(8'h20 + 8'(i), 0, 0, 1);
        rd_chk("R10 overrun again", 5'h10, 32'h8A0);
        set_ctl(ON_RX | 32'h40);
        rd_chk("R2 R10 rx reset", 5'h10, 32'h20);

        // receiver off
        set_ctl(ON_TX);
        send_rx(8'h77, 0, 0, 1);
        rd_chk("R11 ignored status", 5'h10, 32'h20);
        rd_chk("R11 ignored data", 5'h14, 32'h0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule